// File: doc/BRIEF.md
# Low-Speed Mode Clock Divider with Fixed Core-to-Bus Ratio

This block produces the clocks a chip uses in its low-speed fallback mode. Software writes a one-bit mode enable and a 4-bit divide exponent `n` through a write strobe. While the mode is on, the block does three things:

- It raises a bypass request to the PLL.
- It drives a core clock at the base clock frequency divided by 2^n.
- It drives a bus clock at exactly one third of the core clock, with both clocks rising together.

The block is clocked by `clk_ref2x`, a reference that runs at twice the base clock. Every output is therefore a plain flop, and a half-period of the base clock is one reference cycle. With `n = 0` the core clock is the base clock itself: it is high for one reference cycle and low for the next.

A new exponent, or a request to leave the mode, is held until the current bus period has finished. At that point both clocks are low and about to rise together. So a change never shortens or stretches a pulse in the middle of a period. The exponent in force is reported on a status output.

Top module: `limp_clk_divider`

## Requirements
- R1: After a synchronous active-low reset, `core_clk_o`, `bus_clk_o` and `pll_bypass_o` are 0, `exp_active_o` is 0 and the mode is off.
- R2: `cfg_limp` and `cfg_exp` are captured only on a cycle where `cfg_wr` is 1. Without the strobe they have no effect on any output.
- R3: If a write with `cfg_limp = 1` is clocked at edge k while the mode is off, then at edge k+1 `pll_bypass_o`, `core_clk_o` and `bus_clk_o` go to 1 and `exp_active_o` takes the written exponent.
- R4: While running with exponent n in force, every high and every low phase of `core_clk_o` lasts exactly 2^n reference cycles. For n = 0 this is 1 cycle.
- R5: `bus_clk_o` is high for 3·2^n and low for 3·2^n reference cycles. Each bus period holds six core half-periods, and each rising edge of the bus clock coincides with a rising edge of the core clock.
- R6: A new exponent written while running takes effect only at the end of the current bus period. Until then `exp_active_o` and the clock timing keep the old value. If several writes land in one period, the last one wins.
- R7: A write with `cfg_limp = 0` while running lets the current bus period finish. At the edge that ends it, both clocks and `pll_bypass_o` drop to 0 and stay there, and `exp_active_o` keeps its value.
- R8: A write with `cfg_limp = 0` while the mode is off starts no clock and leaves `exp_active_o` unchanged.
- R9: `pll_bypass_o` is 1 whenever either clock output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref2x | input | 1 | Reference clock, twice the base clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_limp | input | 1 | Mode enable value to write |
| cfg_exp | input | 4 | Divide exponent n to write |
| core_clk_o | output | 1 | Core clock, base rate / 2^n |
| bus_clk_o | output | 1 | Bus clock, core clock / 3 |
| pll_bypass_o | output | 1 | Request to bypass the PLL while the mode runs |
| exp_active_o | output | 4 | Exponent currently in force |

## Verification
Mode entry is due one edge after the write edge, so the bench checks the three outputs and the status on the next falling edge. An exponent change or an exit is due at the edge that closes the running bus period, which lasts 6·2^n cycles. The driver therefore checks that the old status still holds right after its write. It then waits for the monitor to count the expected number of completed bus periods before it checks the new status. The monitor samples on every falling edge and measures each completed bus period against an expected core half-period popped from the queue. The driver pushed that value in the order the boundaries are due: the period in flight at the old value, then the new periods.

// File: rtl/limp_clk_pkg.sv
// Package limp_clk_pkg
// Shared defaults and helpers for the low-speed clock divider.
// Assumes nothing beyond IEEE 1800-2017 elaboration rules.
package limp_clk_pkg;
    localparam int unsigned EXP_W_DEF = 4;   // width of the divide exponent
    localparam int unsigned RATIO_DEF = 3;   // core clocks per bus clock

    // Number of core half-periods in one bus period.
    function automatic int unsigned phase_count(input int unsigned ratio);
        return 2 * ratio;
    endfunction
endpackage

// File: rtl/limp_cfg_regs.sv
// Module limp_cfg_regs
// Holds the software-written mode enable and divide exponent.
// Assumes the write strobe is synchronous to clk; the fields load only on it.
module limp_cfg_regs #(
    parameter int unsigned EXP_W = limp_clk_pkg::EXP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             limp_in,
    input  logic [EXP_W-1:0] exp_in,
    output logic             limp_en,
    output logic [EXP_W-1:0] exp_req
);
    // Capture both fields on the write strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limp_en <= 1'b0;
            exp_req <= '0;
        end else if (wr) begin
            limp_en <= limp_in;
            exp_req <= exp_in;
        end
    end
endmodule

// File: rtl/limp_div_engine.sv
// Module limp_div_engine
// Runs the half-period counter, owns the exponent in force and the run flag.
// Assumes period_last comes from the phase generator and marks the final
// half-period of a bus period; settings are only swapped at its end.
module limp_div_engine #(
    parameter int unsigned EXP_W = limp_clk_pkg::EXP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             limp_en,
    input  logic [EXP_W-1:0] exp_req,
    input  logic             period_last,
    output logic             run,
    output logic [EXP_W-1:0] exp_cur,
    output logic             start,
    output logic             half_end,
    output logic             stop
);
    localparam int unsigned CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] lim_m1;
    logic             wrap;

    // Last count of a half-period: 2^exp - 1, wrapping correctly at the top exponent.
    assign one_sh   = (CNT_W + 1)'(1) << exp_cur;
    assign lim_m1   = one_sh[CNT_W-1:0] - CNT_W'(1);
    assign start    = !run && limp_en;
    assign half_end = run && (cnt == lim_m1);
    assign wrap     = half_end && period_last;
    assign stop     = wrap && !limp_en;

    // Advance the counter, start, reload the exponent or stop at a bus-period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            exp_cur <= '0;
            cnt     <= '0;
        end else if (!run) begin
            if (limp_en) begin
                run     <= 1'b1;
                exp_cur <= exp_req;
                cnt     <= '0;
            end
        end else if (half_end) begin
            cnt <= '0;
            if (period_last) begin
                if (!limp_en) run <= 1'b0;
                else          exp_cur <= exp_req;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // The counter never passes the half-period length in force.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1);

    // The exponent changes only on entry or at the end of a bus period.
    assert_exp_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exp_cur) |-> (cnt == '0) && ($past(start) || $past(wrap)));
endmodule

// File: rtl/limp_ratio_gen.sv
// Module limp_ratio_gen
// Steps through the half-periods of one bus period and drives the core and
// bus clock flops: core high on even phases, bus high in the first RATIO.
// Assumes start, half_end and stop come from limp_div_engine in the same cycle.
module limp_ratio_gen #(
    parameter int unsigned RATIO = limp_clk_pkg::RATIO_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    input  logic half_end,
    input  logic stop,
    output logic period_last,
    output logic core_clk,
    output logic bus_clk
);
    localparam int unsigned PHASES = limp_clk_pkg::phase_count(RATIO);
    localparam int unsigned PH_W   = $clog2(PHASES);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] nxt;

    // Final half-period of the bus period and the phase that follows.
    assign period_last = (phase == PH_W'(PHASES - 1));
    assign nxt         = period_last ? '0 : phase + PH_W'(1);

    // Move to the next phase on each half-period end and update both clock flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            core_clk <= 1'b0;
            bus_clk  <= 1'b0;
        end else if (start) begin
            phase    <= '0;
            core_clk <= 1'b1;
            bus_clk  <= 1'b1;
        end else if (half_end) begin
            if (stop) begin
                phase    <= '0;
                core_clk <= 1'b0;
                bus_clk  <= 1'b0;
            end else begin
                phase    <= nxt;
                core_clk <= ~nxt[0];
                bus_clk  <= (nxt < PH_W'(RATIO));
            end
        end
    end

    // Every bus rising edge is also a core rising edge.
    assert_bus_core_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk) |-> $rose(core_clk));

    // Both clocks are held low while the divider is stopped.
    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!core_clk && !bus_clk));
endmodule

// File: rtl/limp_clk_divider.sv
// Module limp_clk_divider
// Top of the low-speed clock divider: configuration register, divide engine
// and core/bus phase generator. Outputs are flops in the clk_ref2x domain.
// Assumes clk_ref2x runs at twice the base clock and reset is synchronous.
module limp_clk_divider #(
    parameter int unsigned EXP_W = limp_clk_pkg::EXP_W_DEF,
    parameter int unsigned RATIO = limp_clk_pkg::RATIO_DEF
) (
    input  logic             clk_ref2x,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_limp,
    input  logic [EXP_W-1:0] cfg_exp,
    output logic             core_clk_o,
    output logic             bus_clk_o,
    output logic             pll_bypass_o,
    output logic [EXP_W-1:0] exp_active_o
);
    logic             limp_en;
    logic [EXP_W-1:0] exp_req;
    logic             run;
    logic             start;
    logic             half_end;
    logic             stop;
    logic             period_last;

    limp_cfg_regs #(.EXP_W(EXP_W)) u_cfg (
        .clk     (clk_ref2x),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .limp_in (cfg_limp),
        .exp_in  (cfg_exp),
        .limp_en (limp_en),
        .exp_req (exp_req)
    );

    limp_div_engine #(.EXP_W(EXP_W)) u_engine (
        .clk         (clk_ref2x),
        .rst_n       (rst_n),
        .limp_en     (limp_en),
        .exp_req     (exp_req),
        .period_last (period_last),
        .run         (run),
        .exp_cur     (exp_active_o),
        .start       (start),
        .half_end    (half_end),
        .stop        (stop)
    );

    limp_ratio_gen #(.RATIO(RATIO)) u_ratio (
        .clk         (clk_ref2x),
        .rst_n       (rst_n),
        .run         (run),
        .start       (start),
        .half_end    (half_end),
        .stop        (stop),
        .period_last (period_last),
        .core_clk    (core_clk_o),
        .bus_clk     (bus_clk_o)
    );

    // The PLL stays bypassed for as long as the divider runs.
    assign pll_bypass_o = run;

    // No clock output is high without the bypass request.
    assert_bypass_cover_R9: assert property (@(posedge clk_ref2x) disable iff (!rst_n)
        (core_clk_o || bus_clk_o) |-> pll_bypass_o);

    // Entering the mode raises both clocks together with the bypass request.
    assert_entry_R3: assert property (@(posedge clk_ref2x) disable iff (!rst_n)
        $rose(pll_bypass_o) |-> (core_clk_o && bus_clk_o));
endmodule

// File: tb/limp_clk_divider_bench.sv
`timescale 1ns/1ps
module limp_clk_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_limp = 1'b0;
    logic [3:0] cfg_exp = 4'd0;
    logic       core_clk_o, bus_clk_o, pll_bypass_o;
    logic [3:0] exp_active_o;

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    bit finished = 1'b0;
    int exp_len[$];

    always #2.5 clk = ~clk;

    limp_clk_divider u_limp_clk_divider (
        .clk_ref2x    (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_limp     (cfg_limp),
        .cfg_exp      (cfg_exp),
        .core_clk_o   (core_clk_o),
        .bus_clk_o    (bus_clk_o),
        .pll_bypass_o (pll_bypass_o),
        .exp_active_o (exp_active_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measures each completed bus period and compares it to the queue.
    bit core_p = 0, bus_p = 0, in_per = 0;
    int core_run = 0, cmin = 0, cmax = 0, halves = 0, bus_hi = 0, total = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!pll_bypass_o) begin
                in_per = 0;
            end else begin
                if (core_clk_o != core_p) begin
                    if (core_run < cmin) cmin = core_run;
                    if (core_run > cmax) cmax = core_run;
                    halves++;
                    core_run = 1;
                end else begin
                    core_run++;
                end
                if (bus_clk_o && !bus_p) begin
                    if (in_per) begin
                        if (exp_len.size() == 0) begin
                            chk(1'b0, "R6 unexpected bus period", total, 0);
                        end else begin
                            int l;
                            l = exp_len.pop_front();
                            chk(cmin == l && cmax == l && halves == 6,
                                "R4 core half-period", cmax, l);
                            chk(total == 6 * l && bus_hi == 3 * l,
                                "R5 bus period", bus_hi, 3 * l);
                        end
                        done_cnt++;
                    end
                    cmin = 1 << 30; cmax = 0; halves = 0; bus_hi = 0; total = 0;
                    in_per = 1;
                end
                total++;
                if (bus_clk_o) bus_hi++;
            end
        end
        core_p = core_clk_o;
        bus_p  = bus_clk_o;
    end

    task automatic wr(input bit limp, input int e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_limp = limp; cfg_exp = 4'(e);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_limp = 1'b0; cfg_exp = 4'd0;
    endtask

    task automatic push(input int e, input int cnt);
        for (int i = 0; i < cnt; i++) exp_len.push_back(1 << e);
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(posedge clk);
    endtask

    // Driver: stimulus sequence with expected items pushed in boundary order.
    initial begin
        int tgt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!core_clk_o && !bus_clk_o && !pll_bypass_o, "R1 clocks low after reset", int'(pll_bypass_o), 0);
        chk(exp_active_o == 0, "R1 exponent after reset", int'(exp_active_o), 0);

        // R2: fields without strobe are ignored
        cfg_limp = 1'b1; cfg_exp = 4'd3;
        repeat (3) @(negedge clk);
        chk(!pll_bypass_o && !core_clk_o, "R2 no strobe no start", int'(pll_bypass_o), 0);
        cfg_limp = 1'b0; cfg_exp = 4'd0;

        // R8: idle write with mode off
        wr(1'b0, 5);
        repeat (3) @(negedge clk);
        chk(!pll_bypass_o && !core_clk_o && !bus_clk_o, "R8 idle write no clock", int'(core_clk_o), 0);
        chk(exp_active_o == 0, "R8 idle write status", int'(exp_active_o), 0);

        // R3: entry with n=2
        push(2, 3);
        wr(1'b1, 2);
        chk(!pll_bypass_o, "R3 not before edge k+1", int'(pll_bypass_o), 0);
        @(negedge clk);
        chk(pll_bypass_o && core_clk_o && bus_clk_o, "R3 entry outputs high", int'(pll_bypass_o), 1);
        chk(exp_active_o == 2, "R3 entry exponent", int'(exp_active_o), 2);
        tgt = 3; wait_done(tgt);

        // R6: change to n=0, deferred to end of the period in flight
        push(2, 1); push(0, 3);
        wr(1'b1, 0);
        chk(exp_active_o == 2, "R6 old exponent held", int'(exp_active_o), 2);
        chk(pll_bypass_o, "R9 bypass while running", int'(pll_bypass_o), 1);
        tgt += 4; wait_done(tgt);
        @(negedge clk);
        chk(exp_active_o == 0, "R6 new exponent applied", int'(exp_active_o), 0);

        // R6: change to n=5
        push(0, 1); push(5, 2);
        wr(1'b1, 5);
        tgt += 3; wait_done(tgt);
        @(negedge clk);
        chk(exp_active_o == 5, "R6 exponent 5 applied", int'(exp_active_o), 5);

        // R6: two writes in one period, last wins
        push(5, 1); push(3, 2);
        wr(1'b1, 1);
        wr(1'b1, 3);
        chk(exp_active_o == 5, "R6 held during double write", int'(exp_active_o), 5);
        tgt += 3; wait_done(tgt);
        @(negedge clk);
        chk(exp_active_o == 3, "R6 last write wins", int'(exp_active_o), 3);

        // R7: exit lets the period finish, then everything low
        wr(1'b0, 7);
        chk(pll_bypass_o, "R7 bypass held until period end", int'(pll_bypass_o), 1);
        repeat (60) @(negedge clk);
        chk(!pll_bypass_o && !core_clk_o && !bus_clk_o, "R7 stopped low", int'(pll_bypass_o), 0);
        chk(exp_active_o == 3, "R7 exponent kept", int'(exp_active_o), 3);
        chk(done_cnt == tgt && exp_len.size() == 0, "R7 no extra period", done_cnt, tgt);
        repeat (20) @(negedge clk);
        chk(!core_clk_o && !bus_clk_o, "R7 stays low", int'(core_clk_o), 0);

        // R3/R4: restart at n=0
        push(0, 2);
        wr(1'b1, 0);
        @(negedge clk);
        chk(pll_bypass_o && core_clk_o && exp_active_o == 0, "R3 restart n=0", int'(exp_active_o), 0);
        tgt += 2; wait_done(tgt);
        wr(1'b0, 0);
        repeat (12) @(negedge clk);
        chk(!pll_bypass_o, "R7 second exit", int'(pll_bypass_o), 0);
        chk(exp_len.size() == 0, "R6 queue drained", exp_len.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule